// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block steers the hazard logic of a five-stage in-order 32-bit integer pipeline. It looks at the source register indices of the instruction sitting in decode and compares them with the destinations of the two older instructions ahead of it. The first of those is in the decode/execute register and the second is in the execute/memory register. From that comparison it picks a bypass source for each of the two execute operands. The selects are registered, so they reach the execute stage together with the instruction they belong to.

The block also finds the case where a load is followed at once by an instruction that reads its result. For that pair it freezes the program counter and the fetch/decode register for one cycle and drops a zeroed bubble into decode/execute. When a branch that resolves in execute proves the fetched path wrong, the block zeroes both younger pipeline registers. A branch flush wins over a load-use stall raised in the same cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When a decode source index is nonzero, equals `idex_rd`, and `idex_we` is 1, and no clear is raised, that operand's select reads 2'b10 (bypass from the execute/memory register) one clock later.
- R2: When a decode source index is nonzero, equals `exmem_rd`, `exmem_we` is 1, and R1 does not apply, that operand's select reads 2'b01 (bypass from the memory/writeback register) one clock later.
- R3: When both older instructions write the same nonzero source index, the select reads 2'b10, because the nearer producer is newer.
- R4: A source index of 0, or a matching producer whose write enable is 0, gives select 2'b00 (register file value).
- R5: The two operand selects are decided independently, so operand A and operand B may show different paths in the same cycle.
- R6: When `idex_load`, `idex_we` and a nonzero `idex_rd` matching either decode source all hold, `hold_front` and `clear_idex` are 1 in the same cycle and `clear_ifid` is 0. A load that matches neither source raises nothing.
- R7: A cycle with `clear_idex` high is followed by both selects at 2'b00, since execute then holds a bubble.
- R8: `mispredict` raises `clear_ifid` and `clear_idex` in the same cycle with `hold_front` at 0.
- R9: When `mispredict` and a load-use hazard coincide, the flush wins: `hold_front` stays 0 and both clears are 1.
- R10: While `rst` is sampled high, both selects become 2'b00 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_rs1 | input | IDX_W | First source index of the instruction in decode |
| dec_rs2 | input | IDX_W | Second source index of the instruction in decode |
| idex_rd | input | IDX_W | Destination index held in decode/execute |
| idex_we | input | 1 | Register write enable held in decode/execute |
| idex_load | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | IDX_W | Destination index held in execute/memory |
| exmem_we | input | 1 | Register write enable held in execute/memory |
| mispredict | input | 1 | Branch in execute resolved against the fetched path |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 01 writeback path, 10 memory path |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| hold_front | output | 1 | Keep the PC and the fetch/decode register |
| clear_ifid | output | 1 | Zero the fetch/decode register |
| clear_idex | output | 1 | Zero the decode/execute register |

## Verification
The stall and clear outputs respond within the cycle to the inputs. The bench drives at the falling edge and reads them one nanosecond later, with no clock edge between. The operand selects pass through one register, so the bench holds the inputs across a single rising edge and reads the selects at the next falling edge. The load-use sequence is followed for one more cycle: the bubble produces empty selects, and the writeback path then serves the dependent operand.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_WX   = 2'b01,
    FWD_MX   = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] near_rd,
  input  logic             near_we,
  input  logic [IDX_W-1:0] far_rd,
  input  logic             far_we,
  output fwd_sel_e         sel
);
  logic src_live, near_hit, far_hit;

  assign src_live = (src_idx != '0);
  assign near_hit = src_live && near_we && (near_rd == src_idx);
  assign far_hit  = src_live && far_we  && (far_rd  == src_idx);

  always_comb begin
    if (near_hit)     sel = FWD_MX;
    else if (far_hit) sel = FWD_WX;
    else              sel = FWD_NONE;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] rs1,
  input  logic [IDX_W-1:0] rs2,
  input  logic [IDX_W-1:0] load_rd,
  input  logic             load_we,
  input  logic             is_load,
  output logic             hazard
);
  logic producer_ok;

  assign producer_ok = is_load && load_we && (load_rd != '0);
  assign hazard = producer_ok && ((rs1 == load_rd) || (rs2 == load_rd));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] dec_rs1,
  input  logic [IDX_W-1:0] dec_rs2,
  input  logic [IDX_W-1:0] idex_rd,
  input  logic             idex_we,
  input  logic             idex_load,
  input  logic [IDX_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic             mispredict,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             hold_front,
  output logic             clear_ifid,
  output logic             clear_idex
);
  localparam int NSRC = 2;

  logic [IDX_W-1:0] src [NSRC];
  fwd_sel_e         sel_nxt [NSRC];
  fwd_sel_e         sel_q   [NSRC];
  logic             lu_hit;

  assign src[0] = dec_rs1;
  assign src[1] = dec_rs2;

  // The decode/execute producer becomes the execute/memory value next
  // cycle, and the execute/memory producer becomes the writeback value.
  for (genvar g = 0; g < NSRC; g++) begin : g_pick
    hz_fwd_pick #(.IDX_W(IDX_W)) u_pick (
      .src_idx (src[g]),
      .near_rd (idex_rd),
      .near_we (idex_we),
      .far_rd  (exmem_rd),
      .far_we  (exmem_we),
      .sel     (sel_nxt[g])
    );
  end

  hz_load_use #(.IDX_W(IDX_W)) u_lu (
    .rs1     (dec_rs1),
    .rs2     (dec_rs2),
    .load_rd (idex_rd),
    .load_we (idex_we),
    .is_load (idex_load),
    .hazard  (lu_hit)
  );

  always_comb begin
    hold_front = lu_hit && !mispredict;
    clear_ifid = mispredict;
    clear_idex = mispredict || lu_hit;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (rst || clear_idex) sel_q[i] <= FWD_NONE;
      else                   sel_q[i] <= sel_nxt[i];
    end
  end

  assign fwd_a_sel = sel_q[0];
  assign fwd_b_sel = sel_q[1];
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] dec_rs1,
  input logic [IDX_W-1:0] idex_rd,
  input logic             idex_we,
  input logic             mispredict,
  input logic [1:0]       fwd_a_sel,
  input logic [1:0]       fwd_b_sel,
  input logic             hold_front,
  input logic             clear_ifid,
  input logic             clear_idex
);
  AST_MX_ON_NEAR: assert property (@(posedge clk) disable iff (rst)
    (!clear_idex && idex_we && idex_rd != '0 && dec_rs1 == idex_rd) |=> fwd_a_sel == 2'b10); // R1
  AST_X0_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (dec_rs1 == '0) |=> fwd_a_sel == 2'b00); // R4
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fwd_a_sel) && $onehot0(fwd_b_sel)); // R3
  AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    hold_front |-> (clear_idex && !clear_ifid)); // R6
  AST_BUBBLE_SEL: assert property (@(posedge clk) disable iff (rst)
    clear_idex |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00)); // R7
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> (!hold_front && clear_ifid && clear_idex)); // R9
  AST_RESET_SEL: assert property (@(posedge clk)
    rst |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00)); // R10
endmodule

bind pipe_hazard_ctrl hz_checker #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_rs1    (dec_rs1),
  .idex_rd    (idex_rd),
  .idex_we    (idex_we),
  .mispredict (mispredict),
  .fwd_a_sel  (fwd_a_sel),
  .fwd_b_sel  (fwd_b_sel),
  .hold_front (hold_front),
  .clear_ifid (clear_ifid),
  .clear_idex (clear_idex)
);

// File: tb/sim_pipe_hazard_ctrl.sv
module sim_pipe_hazard_ctrl;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IDX_W-1:0] dec_rs1 = '0, dec_rs2 = '0, idex_rd = '0, exmem_rd = '0;
  logic idex_we = 1'b0, idex_load = 1'b0, exmem_we = 1'b0, mispredict = 1'b0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic hold_front, clear_ifid, clear_idex;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .mispredict(mispredict),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .hold_front(hold_front),
    .clear_ifid(clear_ifid), .clear_idex(clear_idex)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let combinational outputs settle.
  task automatic drive(int r1, int r2, int ird, bit iwe, bit ild,
                       int erd, bit ewe, bit mp);
    @(negedge clk);
    dec_rs1 = r1[IDX_W-1:0]; dec_rs2 = r2[IDX_W-1:0];
    idex_rd = ird[IDX_W-1:0]; idex_we = iwe; idex_load = ild;
    exmem_rd = erd[IDX_W-1:0]; exmem_we = ewe; mispredict = mp;
    #1;
  endtask

  // Registered selects: one rising edge after the drive.
  task automatic after_edge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 sel A after reset", fwd_a_sel, 0);
    chk("R10 sel B after reset", fwd_b_sel, 0);
    chk("R10 hold idle", hold_front, 0);
  endtask

  task automatic t_mx();
    drive(5, 0, 5, 1, 0, 0, 0, 0);
    chk("R1 no stall on ALU producer", hold_front, 0);
    after_edge();
    chk("R1 sel A memory path", fwd_a_sel, 2);
    chk("R1 sel B untouched", fwd_b_sel, 0);
  endtask

  task automatic t_wx();
    drive(0, 7, 3, 1, 0, 7, 1, 0);
    after_edge();
    chk("R2 sel B writeback path", fwd_b_sel, 1);
  endtask

  task automatic t_both();
    drive(9, 9, 9, 1, 0, 9, 1, 0);
    after_edge();
    chk("R3 sel A newer wins", fwd_a_sel, 2);
    chk("R3 sel B newer wins", fwd_b_sel, 2);
  endtask

  task automatic t_x0();
    drive(0, 0, 0, 1, 0, 0, 1, 0);
    after_edge();
    chk("R4 x0 sel A", fwd_a_sel, 0);
    drive(3, 3, 3, 0, 0, 3, 0, 0);
    after_edge();
    chk("R4 we low sel A", fwd_a_sel, 0);
    chk("R4 we low sel B", fwd_b_sel, 0);
  endtask

  task automatic t_mixed();
    drive(4, 6, 6, 1, 0, 4, 1, 0);
    after_edge();
    chk("R5 sel A writeback", fwd_a_sel, 1);
    chk("R5 sel B memory", fwd_b_sel, 2);
  endtask

  task automatic t_loaduse();
    drive(1, 8, 8, 1, 1, 0, 0, 0);
    chk("R6 hold_front", hold_front, 1);
    chk("R6 clear_idex", clear_idex, 1);
    chk("R6 clear_ifid low", clear_ifid, 0);
    after_edge();
    chk("R7 bubble sel B", fwd_b_sel, 0);
    // Pipeline advanced: bubble in decode/execute, load in execute/memory.
    drive(1, 8, 0, 0, 0, 8, 1, 0);
    chk("R6 stall lasts one cycle", hold_front, 0);
    after_edge();
    chk("R2 load result via writeback", fwd_b_sel, 1);
    drive(3, 2, 8, 1, 1, 0, 0, 0);
    chk("R6 unrelated load no stall", hold_front, 0);
    chk("R6 unrelated load no clear", clear_idex, 0);
  endtask

  task automatic t_mispredict();
    drive(5, 5, 5, 1, 0, 0, 0, 1);
    chk("R8 clear_ifid", clear_ifid, 1);
    chk("R8 clear_idex", clear_idex, 1);
    chk("R8 hold low", hold_front, 0);
    after_edge();
    chk("R8 sel A zero after flush", fwd_a_sel, 0);
  endtask

  task automatic t_flush_over_stall();
    drive(8, 0, 8, 1, 1, 0, 0, 1);
    chk("R9 hold suppressed", hold_front, 0);
    chk("R9 clear_ifid", clear_ifid, 1);
    chk("R9 clear_idex", clear_idex, 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_mx();
    t_wx();
    t_both();
    t_x0();
    t_mixed();
    t_loaduse();
    t_mispredict();
    t_flush_over_stall();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule